// File: doc/BRIEF.md
# Interrupt Event Message Queue

This block gathers status events from a set of data channels and turns each one into a single 32-bit message word. It writes each message through a DMA write port into a ring of words in host memory. That ring is the event channel, channel number 0, and it carries no user data. The host learns every event cause by reading these words from its own memory. It never reads a register in the device.

Each event kind has its own capture register. Three kinds exist: a buffer was handed over, a channel became non-empty, and a quiesce command was acknowledged. A round-robin arbiter takes the waiting events one at a time, and no event is lost while another is being sent. A producer is held off with its ready signal until its previous event has left. When the ring holds as many unread words as it has slots, no further message is issued until the host writes its new read pointer to the doorbell. An interrupt is raised when a word lands in a ring that the host had fully read. The interrupt drops when the host writes the doorbell.

Top module: `emq_top`

## Requirements
- R1: Every message is one 32-bit word with the opcode in bits 31:24, the channel number in bits 23:16 and the argument in bits 15:0. The opcodes are 0x01 for a buffer release, 0x02 for non-empty and 0x03 for a quiesce acknowledge.
- R2: A buffer release on data port p produces channel number p+1 and the argument {buffer index[3:0], byte count[11:0]}. The all-ones index and count are passed through unchanged.
- R3: A quiesce acknowledge produces channel 0 and carries the configuration table length as its argument. Channel 0 is used only by this message.
- R4: A non-empty message (argument 0) is produced once for each low-to-high change of a port's has-data level. It is produced only if that port's enable bit is set; the default mask is 4'b1011, so port 2 is disabled. Holding the level high produces nothing further.
- R5: Events that arrive in the same cycle are sent one at a time in round-robin order over the source list [quiesce, release ports 0..N-1, non-empty ports 0..N-1]. The search starts after the last source granted, and after reset it starts at the quiesce source. Each event is sent exactly once. A producer's ready signal stays low while its previous event of that kind is still waiting.
- R6: The k-th message since reset (counting from 0) is written to address BASE + 4*(k mod DEPTH). A beat whose ready is low keeps its address and data unchanged until it is accepted.
- R7: At most DEPTH words are ever unread: written words minus the host read pointer. At that limit no beat is issued and waiting producers stay stalled. Sending resumes after the doorbell frees space.
- R8: The interrupt rises in the cycle after a word is accepted while every earlier word had been read (written count equal to the host pointer). It falls in the cycle after a doorbell write. A word accepted into a ring that still holds unread words does not raise it.
- R9: After reset the interrupt and the DMA valid are low, and every ready output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rel_valid | input | NCH | Per-port buffer release strobe |
| rel_ready | output | NCH | Per-port release capture free |
| rel_buf | input | NCH*BUF_W | Per-port released buffer index |
| rel_cnt | input | NCH*CNT_W | Per-port valid byte count |
| has_data | input | NCH | Per-port level, high while the channel holds data |
| qa_valid | input | 1 | Quiesce acknowledge strobe |
| qa_ready | output | 1 | Quiesce capture free |
| qa_len | input | 16 | Configuration table length |
| db_valid | input | 1 | Host doorbell write |
| db_rptr | input | PTR_W | Host read pointer, including the wrap bit |
| dma_valid | output | 1 | Message beat valid |
| dma_ready | input | 1 | Message beat accepted |
| dma_addr | output | ADDR_W | Host byte address of the beat |
| dma_data | output | 32 | Message word |
| irq | output | 1 | Interrupt to the host |

## Verification
The bench first drives single events of each kind: quiesce, release with mid-range and all-ones fields, and non-empty on enabled and disabled ports. These show that each word is formed correctly on its own. It then raises five sources in the same cycle while DMA ready stalls in a pseudo-random pattern. This separates true round-robin serialization and beat holding from a fixed priority or a dropped event. A run of releases longer than the ring shows the stall at the full mark and the resume after the doorbell. Partial and full doorbells show which written words may raise the interrupt.

// File: rtl/emq_pkg.sv
package emq_pkg;

    typedef enum logic [7:0] {
        OP_NONE     = 8'h00,
        OP_RELEASE  = 8'h01,
        OP_NONEMPTY = 8'h02,
        OP_QACK     = 8'h03
    } emq_op_e;

    typedef struct packed {
        emq_op_e     op;
        logic [7:0]  chan;
        logic [15:0] arg;
    } emq_msg_t;

    function automatic emq_msg_t emq_make(emq_op_e op, logic [7:0] chan, logic [15:0] arg);
        emq_msg_t m;
        m.op   = op;
        m.chan = chan;
        m.arg  = arg;
        return m;
    endfunction

endpackage

// File: rtl/emq_src.sv
module emq_src
    import emq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int BUF_W = 4,
    parameter int CNT_W = 12,
    parameter logic [NCH-1:0] NE_EN = 4'b1011,
    localparam int NSRC = 2*NCH + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NCH-1:0]         rel_valid,
    output logic [NCH-1:0]         rel_ready,
    input  logic [NCH*BUF_W-1:0]   rel_buf,
    input  logic [NCH*CNT_W-1:0]   rel_cnt,
    input  logic [NCH-1:0]         has_data,
    input  logic                   qa_valid,
    output logic                   qa_ready,
    input  logic [15:0]            qa_len,
    input  logic [NSRC-1:0]        clr,
    output logic [NSRC-1:0]        req,
    output emq_msg_t               msg [NSRC]
);

    logic        qa_pend_q;
    logic [15:0] qa_len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            qa_pend_q <= 1'b0;
            qa_len_q  <= '0;
        end else if (qa_valid && !qa_pend_q) begin
            qa_pend_q <= 1'b1;
            qa_len_q  <= qa_len;
        end else if (clr[0]) begin
            qa_pend_q <= 1'b0;
        end
    end

    assign qa_ready = !qa_pend_q;
    assign req[0]   = qa_pend_q;
    assign msg[0]   = emq_make(OP_QACK, 8'd0, qa_len_q);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic             rel_pend_q;
        logic [BUF_W-1:0] buf_q;
        logic [CNT_W-1:0] cnt_q;
        logic             ne_pend;

        always_ff @(posedge clk) begin
            if (rst) begin
                rel_pend_q <= 1'b0;
                buf_q      <= '0;
                cnt_q      <= '0;
            end else if (rel_valid[i] && !rel_pend_q) begin
                rel_pend_q <= 1'b1;
                buf_q      <= rel_buf[i*BUF_W +: BUF_W];
                cnt_q      <= rel_cnt[i*CNT_W +: CNT_W];
            end else if (clr[1+i]) begin
                rel_pend_q <= 1'b0;
            end
        end

        assign rel_ready[i] = !rel_pend_q;
        assign req[1+i]     = rel_pend_q;
        assign msg[1+i]     = emq_make(OP_RELEASE, 8'(i+1), 16'({buf_q, cnt_q}));

        if (NE_EN[i]) begin : g_ne
            logic prev_q, pend_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= 1'b0;
                    pend_q <= 1'b0;
                end else begin
                    prev_q <= has_data[i];
                    if (has_data[i] && !prev_q) pend_q <= 1'b1;
                    else if (clr[1+NCH+i])      pend_q <= 1'b0;
                end
            end
            assign ne_pend = pend_q;
        end else begin : g_no_ne
            assign ne_pend = 1'b0;
        end

        assign req[1+NCH+i] = ne_pend;
        assign msg[1+NCH+i] = emq_make(OP_NONEMPTY, 8'(i+1), 16'd0);
    end

endmodule

// File: rtl/emq_rr_arb.sv
module emq_rr_arb #(
    parameter int N = 9,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    input  logic             advance,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             any
);

    logic [IDX_W-1:0] last_q;

    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        any     = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last_q) + k) % N;
            if (!any && req[idx]) begin
                any     = 1'b1;
                gnt_idx = IDX_W'(idx);
            end
        end
        if (any) gnt[gnt_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          last_q <= IDX_W'(N-1);
        else if (advance) last_q <= gnt_idx;
    end

endmodule

// File: rtl/emq_ring.sv
module emq_ring
    import emq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE = 32'h0000_1000,
    localparam int PTR_W = $clog2(DEPTH) + 1,
    localparam int SLOT_W = PTR_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  emq_msg_t          msg_in,
    output logic              can_take,
    input  logic              db_valid,
    input  logic [PTR_W-1:0]  db_rptr,
    input  logic              dma_ready,
    output logic              dma_valid,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [31:0]       dma_data,
    output logic              irq
);

    logic [PTR_W-1:0]  wptr_q, cptr_q, rptr_q;
    logic              vld_q, irq_q;
    emq_msg_t          data_q;
    logic [ADDR_W-1:0] addr_q;
    logic [PTR_W-1:0]  used;
    logic              full, hs;

    assign used     = wptr_q - rptr_q;
    assign full     = (used == PTR_W'(DEPTH));
    assign hs       = vld_q && dma_ready;
    assign can_take = !full && (!vld_q || dma_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            cptr_q <= '0;
            rptr_q <= '0;
            vld_q  <= 1'b0;
            irq_q  <= 1'b0;
            data_q <= '0;
            addr_q <= '0;
        end else begin
            if (take) begin
                vld_q  <= 1'b1;
                data_q <= msg_in;
                addr_q <= BASE + ADDR_W'({wptr_q[SLOT_W-1:0], 2'b00});
                wptr_q <= wptr_q + 1'b1;
            end else if (hs) begin
                vld_q <= 1'b0;
            end
            if (hs) cptr_q <= cptr_q + 1'b1;
            if (db_valid) rptr_q <= db_rptr;
            if (hs && cptr_q == rptr_q) irq_q <= 1'b1;
            else if (db_valid)          irq_q <= 1'b0;
        end
    end

    assign dma_valid = vld_q;
    assign dma_addr  = addr_q;
    assign dma_data  = data_q;
    assign irq       = irq_q;

endmodule

// File: rtl/emq_top.sv
module emq_top
    import emq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DEPTH = 8,
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE = 32'h0000_1000,
    parameter int BUF_W = 4,
    parameter int CNT_W = 12,
    parameter logic [NCH-1:0] NE_EN = 4'b1011,
    localparam int PTR_W = $clog2(DEPTH) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       rel_valid,
    output logic [NCH-1:0]       rel_ready,
    input  logic [NCH*BUF_W-1:0] rel_buf,
    input  logic [NCH*CNT_W-1:0] rel_cnt,
    input  logic [NCH-1:0]       has_data,
    input  logic                 qa_valid,
    output logic                 qa_ready,
    input  logic [15:0]          qa_len,
    input  logic                 db_valid,
    input  logic [PTR_W-1:0]     db_rptr,
    output logic                 dma_valid,
    input  logic                 dma_ready,
    output logic [ADDR_W-1:0]    dma_addr,
    output logic [31:0]          dma_data,
    output logic                 irq
);

    localparam int NSRC  = 2*NCH + 1;
    localparam int IDX_W = $clog2(NSRC);

    logic [NSRC-1:0]  req, gnt, clr;
    logic [IDX_W-1:0] gnt_idx;
    logic             any, can_take, advance;
    emq_msg_t         src_msg [NSRC];

    emq_src #(.NCH(NCH), .BUF_W(BUF_W), .CNT_W(CNT_W), .NE_EN(NE_EN)) u_src (
        .clk(clk), .rst(rst),
        .rel_valid(rel_valid), .rel_ready(rel_ready),
        .rel_buf(rel_buf), .rel_cnt(rel_cnt),
        .has_data(has_data),
        .qa_valid(qa_valid), .qa_ready(qa_ready), .qa_len(qa_len),
        .clr(clr), .req(req), .msg(src_msg)
    );

    emq_rr_arb #(.N(NSRC)) u_arb (
        .clk(clk), .rst(rst), .req(req), .advance(advance),
        .gnt(gnt), .gnt_idx(gnt_idx), .any(any)
    );

    assign advance = any && can_take;
    assign clr     = gnt & {NSRC{advance}};

    emq_ring #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BASE(BASE)) u_ring (
        .clk(clk), .rst(rst),
        .take(advance), .msg_in(src_msg[gnt_idx]), .can_take(can_take),
        .db_valid(db_valid), .db_rptr(db_rptr),
        .dma_ready(dma_ready), .dma_valid(dma_valid),
        .dma_addr(dma_addr), .dma_data(dma_data), .irq(irq)
    );

endmodule

// File: rtl/emq_chk.sv
module emq_chk #(
    parameter int NCH = 4,
    parameter int DEPTH = 8,
    parameter int ADDR_W = 32,
    parameter logic [NCH-1:0] NE_EN = 4'b1011,
    localparam int PTR_W = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              dma_valid,
    input logic              dma_ready,
    input logic [ADDR_W-1:0] dma_addr,
    input logic [31:0]       dma_data,
    input logic              db_valid,
    input logic [PTR_W-1:0]  db_rptr,
    input logic              irq
);

    logic [PTR_W-1:0] sent_q, host_q, unread;

    always_ff @(posedge clk) begin
        if (rst) begin
            sent_q <= '0;
            host_q <= '0;
        end else begin
            if (dma_valid && dma_ready) sent_q <= sent_q + 1'b1;
            if (db_valid) host_q <= db_rptr;
        end
    end

    assign unread = sent_q - host_q;

    function automatic logic ne_allowed(logic [7:0] ch);
        logic ok;
        ok = 1'b0;
        for (int i = 0; i < NCH; i++)
            if (ch == 8'(i+1)) ok = NE_EN[i];
        return ok;
    endfunction

    a_r6_beat_hold: assert property (@(posedge clk) disable iff (rst)
        dma_valid && !dma_ready |=> dma_valid && $stable(dma_data) && $stable(dma_addr));

    a_r6_word_align: assert property (@(posedge clk) disable iff (rst)
        dma_valid |-> dma_addr[1:0] == 2'b00);

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        unread <= PTR_W'(DEPTH));

    a_r8_irq_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(dma_valid && dma_ready));

    a_r8_irq_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(db_valid));

    a_r4_ne_mask: assert property (@(posedge clk) disable iff (rst)
        dma_valid && dma_data[31:24] == 8'h02 |-> ne_allowed(dma_data[23:16]));

    a_r3_chan0_only_qack: assert property (@(posedge clk) disable iff (rst)
        dma_valid && dma_data[23:16] == 8'h00 |-> dma_data[31:24] == 8'h03);

endmodule

bind emq_top emq_chk #(.NCH(NCH), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .NE_EN(NE_EN)) u_chk (
    .clk(clk), .rst(rst), .dma_valid(dma_valid), .dma_ready(dma_ready),
    .dma_addr(dma_addr), .dma_data(dma_data), .db_valid(db_valid),
    .db_rptr(db_rptr), .irq(irq)
);

// File: tb/emq_top_bench.sv
module emq_top_bench;
    localparam int NCH = 4, DEPTH = 8, BUF_W = 4, CNT_W = 12, PTR_W = 4;
    localparam int NSRC = 2*NCH + 1;
    localparam logic [31:0] BASE = 32'h0000_1000;

    logic clk = 1'b0, rst = 1'b1;
    always #5 clk = ~clk;

    logic [NCH-1:0]       rel_valid = '0, rel_ready, has_data = '0;
    logic [NCH*BUF_W-1:0] rel_buf = '0;
    logic [NCH*CNT_W-1:0] rel_cnt = '0;
    logic                 qa_valid = 1'b0, qa_ready, db_valid = 1'b0;
    logic [15:0]          qa_len = '0;
    logic [PTR_W-1:0]     db_rptr = '0;
    logic                 dma_valid, dma_ready = 1'b1, irq;
    logic [31:0]          dma_addr, dma_data;

    emq_top u_emq_top (
        .clk(clk), .rst(rst), .rel_valid(rel_valid), .rel_ready(rel_ready),
        .rel_buf(rel_buf), .rel_cnt(rel_cnt), .has_data(has_data),
        .qa_valid(qa_valid), .qa_ready(qa_ready), .qa_len(qa_len),
        .db_valid(db_valid), .db_rptr(db_rptr), .dma_valid(dma_valid),
        .dma_ready(dma_ready), .dma_addr(dma_addr), .dma_data(dma_data), .irq(irq)
    );

    int total = 0, bad = 0, ccnt = 0, hp = 0, last_src = NSRC - 1;
    logic [31:0] expq[$];
    logic [31:0] exp_w, exp_a;
    bit stall_mode = 1'b0, finished = 1'b0;
    logic [7:0] lfsr = 8'h5a;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int op, input int ch, input int arg);
        return {8'(op), 8'(ch), 16'(arg)};
    endfunction

    // ready pattern, changed away from both edges used by the bench
    always @(posedge clk) begin
        #2;
        if (stall_mode) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            dma_ready = lfsr[0];
        end else begin
            dma_ready = 1'b1;
        end
    end

    // monitor: pops the scoreboard on every accepted beat
    always @(negedge clk) begin
        if (!rst && dma_valid && dma_ready) begin
            exp_a = BASE + 32'((ccnt % DEPTH) * 4);
            if (expq.size() == 0) begin
                chk(1'b0, "R5 unexpected message", dma_data, 32'h0);
            end else begin
                exp_w = expq.pop_front();
                chk(dma_data == exp_w, "R1 message word", dma_data, exp_w);
            end
            chk(dma_addr == exp_a, "R6 address", dma_addr, exp_a);
            ccnt++;
        end
    end

    task automatic send_rel(input int p, input int b, input int c);
        @(negedge clk);
        while (!rel_ready[p]) @(negedge clk);
        rel_valid[p] = 1'b1;
        rel_buf[p*BUF_W +: BUF_W] = BUF_W'(b);
        rel_cnt[p*CNT_W +: CNT_W] = CNT_W'(c);
        expq.push_back(mk(1, p + 1, (b << 12) | (c & 12'hfff)));
        last_src = 1 + p;
        @(negedge clk);
        rel_valid[p] = 1'b0;
    endtask

    task automatic send_qa(input int len);
        @(negedge clk);
        while (!qa_ready) @(negedge clk);
        qa_valid = 1'b1;
        qa_len = 16'(len);
        expq.push_back(mk(3, 0, len));
        last_src = 0;
        @(negedge clk);
        qa_valid = 1'b0;
    endtask

    task automatic set_data(input int p, input bit v, input bit expect_msg);
        @(negedge clk);
        has_data[p] = v;
        if (expect_msg) begin
            expq.push_back(mk(2, p + 1, 0));
            last_src = 1 + NCH + p;
        end
    endtask

    task automatic doorbell(input int ptr);
        @(negedge clk);
        hp = ptr;
        db_valid = 1'b1;
        db_rptr = PTR_W'(ptr);
        @(negedge clk);
        db_valid = 1'b0;
    endtask

    task automatic drain;
        int n = 0;
        while (expq.size() != 0 && n < 400) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
        chk(expq.size() == 0, "R5 all expected messages delivered", 32'(expq.size()), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] srcw [NSRC];
        bit          sel  [NSRC];
        int          base_cnt;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(irq == 1'b0, "R9 irq low after reset", 32'(irq), 32'h0);
        chk(dma_valid == 1'b0, "R9 dma_valid low after reset", 32'(dma_valid), 32'h0);
        chk(rel_ready == '1 && qa_ready, "R9 readies high after reset", 32'({rel_ready, qa_ready}), 32'h1f);

        // R3 quiesce acknowledge, R8 irq on write into empty ring
        send_qa(16'h0123);
        drain();
        chk(irq == 1'b1, "R8 irq after write into empty ring", 32'(irq), 32'h1);

        // R2 release fields, including all-ones boundary
        send_rel(0, 5, 12'h7ff);
        send_rel(3, 15, 12'hfff);
        drain();
        doorbell(ccnt - 1);
        @(negedge clk);
        chk(irq == 1'b0, "R8 irq falls after doorbell", 32'(irq), 32'h0);
        send_rel(1, 2, 12'h001);
        drain();
        chk(irq == 1'b0, "R8 no irq for write into nonempty ring", 32'(irq), 32'h0);
        doorbell(ccnt);

        // R4 nonempty edge, held level, disabled port
        set_data(0, 1'b1, 1'b1);
        drain();
        chk(irq == 1'b1, "R8 irq after nonempty into empty ring", 32'(irq), 32'h1);
        repeat (20) @(negedge clk);
        chk(ccnt == 5, "R4 no repeat while level held high", 32'(ccnt), 32'd5);
        set_data(0, 1'b0, 1'b0);
        set_data(0, 1'b1, 1'b1);
        drain();
        set_data(0, 1'b0, 1'b0);
        set_data(2, 1'b1, 1'b0);
        repeat (20) @(negedge clk);
        chk(ccnt == 6, "R4 disabled port produces nothing", 32'(ccnt), 32'd6);
        set_data(2, 1'b0, 1'b0);
        doorbell(ccnt);

        // R5 simultaneous sources under a stalling DMA port
        stall_mode = 1'b1;
        for (int i = 0; i < NSRC; i++) sel[i] = 1'b0;
        srcw[0] = mk(3, 0, 16'h0abc);
        for (int p = 0; p < NCH; p++) begin
            srcw[1+p]     = mk(1, p + 1, ((p + 8) << 12) | (12'h100 + p));
            srcw[1+NCH+p] = mk(2, p + 1, 0);
        end
        sel[0] = 1'b1; sel[1] = 1'b1; sel[2] = 1'b1; sel[3] = 1'b1; sel[1+NCH+1] = 1'b1;
        @(negedge clk);
        qa_valid = 1'b1;
        qa_len = 16'h0abc;
        for (int p = 0; p < 3; p++) begin
            rel_valid[p] = 1'b1;
            rel_buf[p*BUF_W +: BUF_W] = BUF_W'(p + 8);
            rel_cnt[p*CNT_W +: CNT_W] = CNT_W'(12'h100 + p);
        end
        has_data[1] = 1'b1;
        for (int k = 1; k <= NSRC; k++) begin
            int idx;
            idx = (last_src + k) % NSRC;
            if (sel[idx]) expq.push_back(srcw[idx]);
        end
        last_src = 1 + NCH + 1;
        for (int k = 1; k <= NSRC; k++) begin
            int idx;
            idx = (NSRC - 1 + k) % NSRC;
            if (idx != 0 && idx <= 1 + NCH + 1 && sel[idx]) last_src = idx;
        end
        @(negedge clk);
        qa_valid = 1'b0;
        rel_valid = '0;
        chk(rel_ready[0] == 1'b0, "R5 ready low while event waits", 32'(rel_ready), 32'h0);
        drain();
        has_data[1] = 1'b0;
        stall_mode = 1'b0;
        doorbell(ccnt);

        // R7 ring full stall and resume
        base_cnt = ccnt;
        for (int k = 0; k < DEPTH + 1; k++) send_rel(1, k % 16, k);
        repeat (30) @(negedge clk);
        chk(ccnt == base_cnt + DEPTH, "R7 writes stop at ring depth", 32'(ccnt), 32'(base_cnt + DEPTH));
        chk(rel_ready[1] == 1'b0, "R7 producer stalled when full", 32'(rel_ready[1]), 32'h0);
        chk(dma_valid == 1'b0, "R7 no beat while full", 32'(dma_valid), 32'h0);
        doorbell(ccnt);
        drain();
        chk(ccnt == base_cnt + DEPTH + 1, "R7 resume after doorbell", 32'(ccnt), 32'(base_cnt + DEPTH + 1));
        chk(rel_ready[1] == 1'b1, "R7 producer released", 32'(rel_ready[1]), 32'h1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule